// File: doc/BRIEF.md
# One-Time-Programmable Fuse Register Bank

This block models a bank of one-time-programmable fuses that holds three registers: a 256-bit secret key, a 57-bit factory identifier that can only be read, and a 32-bit control word. Every logical bit of the key and control registers sits on a pair of cells, a primary and a redundant one. A flop holds the sensed value of each pair, which is the OR of the two cells. The sense flops load once just after reset is released and again on every capture strobe.

All access goes through a serial port. A two-bit select picks one register. A capture strobe first refreshes the sense flops and, one cycle later, loads the shift chain of every register. Shift cycles then move the selected chain one position per clock. Bits enter on the serial input while the chain presents its next bit on the serial output. A program strobe ORs the data now held in the selected chain into both cells of that register. Fuses therefore only ever gain ones.

Four control bits act as locks, in two pairs that are redundant copies of each other. A lock pair masks readback of its register to zeros and drops program strobes aimed at it. The locks are read from the sense flops, so a newly burnt lock takes effect at the next capture or reset. Fuse burning physics, voltage sequencing and any consumer of the key are not modelled. The fuse cells take their parameter images at reset.

Top module: `otp_fuse_bank`

## Requirements
- R1: One clock edge after reset release, and on each capture edge, the sensed value of every logical bit becomes the OR of its primary and redundant cells. A capture asserted on edge N loads the shift chains on edge N+1.
- R2: Key readback and key programming use the order index 255 first and index 0 last. The serial output shows the next bit combinationally from the chain, and the input bit enters on the same shift edge.
- R3: Control readback and control programming use the order index 0 first and index 31 last.
- R4: The identifier reads out as its 57-bit value with index 56 first. A program strobe with the identifier selected changes nothing.
- R5: A program strobe sets both cells of every bit whose chain data is 1. A 0 programmed over a 1 leaves the 1, and no fuse bit ever returns to 0.
- R6: When sensed control bit 9 or bit 14 is 1, the key register is locked. Its readback shifts out only zeros and key program strobes are ignored. Either copy alone is enough, and so is either cell of a copy.
- R7: When sensed control bit 7 or bit 12 is 1, the control register is locked. Its readback shifts out only zeros and control program strobes are ignored. Either copy alone is enough.
- R8: The lock check uses only the lock bits sensed before the strobe. A program operation that writes a lock bit also writes every other 1 in the same data.
- R9: The select codes are 00 for the key, 01 for the identifier, 10 for the control register and 11 for none. With code 11 the serial output is 0. A lock never releases once sensed.
- R10: During reset and until the first capture, every chain holds zeros and the serial output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; cells load their parameter images |
| sel_i | input | 2 | Register select: 00 key, 01 identifier, 10 control, 11 none |
| shift_i | input | 1 | Shift the selected chain one position |
| tdi_i | input | 1 | Serial data in |
| capture_i | input | 1 | Re-sense fuses, then load all chains on the next edge |
| program_i | input | 1 | Burn the selected chain contents into the selected register |
| tdo_o | output | 1 | Serial data out of the selected chain |

## Verification
A cleared fuse, a broken cell pair or a wrong lock state stays hidden until the next capture. After that it appears at the serial output within two clocks plus the length of the affected register in shift cycles. It shows as a bit stream that differs from the OR of everything programmed so far. An order error in one register shows as a mirrored stream on the first readback of an asymmetric pattern. A lock that was not sensed shows as key or control data where zeros are due. A lock that fires too early shows as zeros where data is due. Separate bank instances carry lock bits in their parameter images, so each lock copy, and the redundant cell behind it, is exercised without the other copy.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

   typedef enum logic [1:0] {
      SEL_KEY  = 2'b00,
      SEL_ID   = 2'b01,
      SEL_CTRL = 2'b10,
      SEL_NONE = 2'b11
   } otp_sel_e;

   localparam int unsigned KEY_BITS_DEF  = 256;
   localparam int unsigned ID_BITS_DEF   = 57;
   localparam int unsigned CTRL_BITS_DEF = 32;

endpackage

// File: rtl/otp_cell_array.sv
// Pairs of fuse cells with a sense flop per logical bit.
module otp_cell_array #(
   parameter int unsigned W        = 8,
   parameter logic [W-1:0] PRI_INIT = '0,
   parameter logic [W-1:0] RED_INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         prog_i,
   input  logic         lock_i,
   input  logic [W-1:0] data_i,
   input  logic         sense_i,
   output logic [W-1:0] sensed_o
);

   logic [W-1:0] pri_q;
   logic [W-1:0] red_q;
   logic [W-1:0] sense_q;

   if (W < 1) begin : g_bad_width
      $error("otp_cell_array: W must be at least 1");
   end

   // Cells only accumulate ones; the reset value stands for the burnt image.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_q <= PRI_INIT;
         red_q <= RED_INIT;
      end else if (prog_i && !lock_i) begin
         pri_q <= pri_q | data_i;
         red_q <= red_q | data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
      end else if (sense_i) begin
         sense_q <= pri_q | red_q;
      end
   end

   assign sensed_o = sense_q;

   AST_FUSE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (((~pri_q) & $past(pri_q)) == '0) && (((~red_q) & $past(red_q)) == '0)); // R5

   AST_PROG_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_i && !lock_i) |=> ((pri_q & red_q & $past(data_i)) == $past(data_i))); // R5

   AST_LOCKED_PROG_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_i && lock_i) |=> ($stable(pri_q) && $stable(red_q))); // R6

endmodule

// File: rtl/otp_shift_chain.sv
// Writable serial chain; MSB_FIRST selects which end of the register leaves first.
module otp_shift_chain #(
   parameter int unsigned W         = 8,
   parameter bit          MSB_FIRST = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_i,
   input  logic         tdi_i,
   input  logic         load_i,
   input  logic         zero_i,
   input  logic [W-1:0] image_i,
   output logic [W-1:0] data_o,
   output logic         tdo_o
);

   logic [W-1:0] chain_q;
   logic [W-1:0] load_img;

   if (W < 2) begin : g_bad_width
      $error("otp_shift_chain: W must be at least 2");
   end

   // chain_q[0] always leaves first; the first bit shifted in ends at index 0.
   if (MSB_FIRST) begin : g_msb_first
      for (genvar i = 0; i < W; i++) begin : g_rev
         assign load_img[i] = image_i[W-1-i];
         assign data_o[i]   = chain_q[W-1-i];
      end
   end else begin : g_lsb_first
      assign load_img = image_i;
      assign data_o   = chain_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else if (load_i) begin
         chain_q <= zero_i ? '0 : load_img;
      end else if (shift_i) begin
         chain_q <= {tdi_i, chain_q[W-1:1]};
      end
   end

   assign tdo_o = chain_q[0];

   AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && zero_i) |=> (chain_q == '0)); // R6

endmodule

// File: rtl/otp_id_chain.sv
// Read-only identifier chain, highest index first, zeros fill behind.
module otp_id_chain #(
   parameter int unsigned  W        = 57,
   parameter logic [W-1:0] ID_VALUE = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_i,
   input  logic load_i,
   output logic tdo_o
);

   logic [W-1:0] chain_q;
   logic [W-1:0] id_rev;

   if (W < 2) begin : g_bad_width
      $error("otp_id_chain: W must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_rev
      assign id_rev[i] = ID_VALUE[W-1-i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else if (load_i) begin
         chain_q <= id_rev;
      end else if (shift_i) begin
         chain_q <= {1'b0, chain_q[W-1:1]};
      end
   end

   assign tdo_o = chain_q[0];

   AST_ID_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (tdo_o == ID_VALUE[W-1])); // R4

endmodule

// File: rtl/otp_fuse_bank.sv
module otp_fuse_bank
   import otp_fuse_pkg::*;
#(
   parameter int unsigned KEY_W       = KEY_BITS_DEF,
   parameter int unsigned ID_W        = ID_BITS_DEF,
   parameter int unsigned CTRL_W      = CTRL_BITS_DEF,
   parameter int unsigned CTRL_LOCK_A = 7,
   parameter int unsigned CTRL_LOCK_B = 12,
   parameter int unsigned KEY_LOCK_A  = 9,
   parameter int unsigned KEY_LOCK_B  = 14,
   parameter logic [ID_W-1:0]   ID_VALUE      = '0,
   parameter logic [KEY_W-1:0]  KEY_PRI_INIT  = '0,
   parameter logic [KEY_W-1:0]  KEY_RED_INIT  = '0,
   parameter logic [CTRL_W-1:0] CTRL_PRI_INIT = '0,
   parameter logic [CTRL_W-1:0] CTRL_RED_INIT = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel_i,
   input  logic       shift_i,
   input  logic       tdi_i,
   input  logic       capture_i,
   input  logic       program_i,
   output logic       tdo_o
);

   if (CTRL_LOCK_A >= CTRL_W || CTRL_LOCK_B >= CTRL_W ||
       KEY_LOCK_A >= CTRL_W || KEY_LOCK_B >= CTRL_W) begin : g_bad_lock_pos
      $error("otp_fuse_bank: lock bit positions must fall inside the control word");
   end
   if (CTRL_LOCK_A == CTRL_LOCK_B || KEY_LOCK_A == KEY_LOCK_B ||
       CTRL_LOCK_A == KEY_LOCK_A || CTRL_LOCK_B == KEY_LOCK_B) begin : g_bad_lock_dup
      $error("otp_fuse_bank: lock bit positions must be distinct");
   end

   otp_sel_e sel;
   assign sel = otp_sel_e'(sel_i);

   logic init_q;
   logic cap_q;
   logic sense_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= 1'b0;
         cap_q  <= 1'b0;
      end else begin
         init_q <= 1'b1;
         cap_q  <= capture_i;
      end
   end

   assign sense_en = capture_i | ~init_q;

   logic [KEY_W-1:0]  key_sensed;
   logic [KEY_W-1:0]  key_data;
   logic [CTRL_W-1:0] ctrl_sensed;
   logic [CTRL_W-1:0] ctrl_data;
   logic key_lock, ctrl_lock;
   logic key_tdo, id_tdo, ctrl_tdo;

   assign key_lock  = ctrl_sensed[KEY_LOCK_A]  | ctrl_sensed[KEY_LOCK_B];
   assign ctrl_lock = ctrl_sensed[CTRL_LOCK_A] | ctrl_sensed[CTRL_LOCK_B];

   otp_cell_array #(.W(KEY_W), .PRI_INIT(KEY_PRI_INIT), .RED_INIT(KEY_RED_INIT)) key_cells_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog_i   (program_i && (sel == SEL_KEY)),
      .lock_i   (key_lock),
      .data_i   (key_data),
      .sense_i  (sense_en),
      .sensed_o (key_sensed)
   );

   otp_shift_chain #(.W(KEY_W), .MSB_FIRST(1'b1)) key_chain_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (shift_i && (sel == SEL_KEY)),
      .tdi_i   (tdi_i),
      .load_i  (cap_q),
      .zero_i  (key_lock),
      .image_i (key_sensed),
      .data_o  (key_data),
      .tdo_o   (key_tdo)
   );

   otp_id_chain #(.W(ID_W), .ID_VALUE(ID_VALUE)) id_chain_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (shift_i && (sel == SEL_ID)),
      .load_i  (cap_q),
      .tdo_o   (id_tdo)
   );

   otp_cell_array #(.W(CTRL_W), .PRI_INIT(CTRL_PRI_INIT), .RED_INIT(CTRL_RED_INIT)) ctrl_cells_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog_i   (program_i && (sel == SEL_CTRL)),
      .lock_i   (ctrl_lock),
      .data_i   (ctrl_data),
      .sense_i  (sense_en),
      .sensed_o (ctrl_sensed)
   );

   otp_shift_chain #(.W(CTRL_W), .MSB_FIRST(1'b0)) ctrl_chain_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (shift_i && (sel == SEL_CTRL)),
      .tdi_i   (tdi_i),
      .load_i  (cap_q),
      .zero_i  (ctrl_lock),
      .image_i (ctrl_sensed),
      .data_o  (ctrl_data),
      .tdo_o   (ctrl_tdo)
   );

   always_comb begin
      case (sel)
         SEL_KEY:  tdo_o = key_tdo;
         SEL_ID:   tdo_o = id_tdo;
         SEL_CTRL: tdo_o = ctrl_tdo;
         default:  tdo_o = 1'b0;
      endcase
   end

   AST_KEY_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      key_lock |=> key_lock); // R9

   AST_CTRL_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_lock |=> ctrl_lock); // R7

   AST_IDLE_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == 2'b11) |-> (tdo_o == 1'b0)); // R9

endmodule

// File: tb/otp_fuse_bank_tb.sv
module otp_fuse_bank_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 30000;

   localparam logic [56:0]  ID_V    = 57'h1_3579_BDF0_2468_AC;
   localparam logic [255:0] KEY_PI  = (256'd1 << 3) | (256'd1 << 250);
   localparam logic [255:0] KEY_RI  = (256'd1 << 128) | (256'd1 << 7);
   localparam logic [255:0] KEY_OR  = KEY_PI | KEY_RI;
   localparam logic [31:0]  CTRL_PI = 32'h0000_0002;
   localparam logic [31:0]  CTRL_RI = 32'h4000_0000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel = 2'b11;
   logic       tdi = 1'b0;
   logic [2:0] shift_v = '0;
   logic [2:0] cap_v = '0;
   logic [2:0] prog_v = '0;
   logic [2:0] tdo_v;

   int checks = 0;
   int errors = 0;
   int mon_inst = 0;
   bit done = 0;

   typedef struct {
      logic  val;
      string tag;
      int    pos;
   } exp_t;

   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   otp_fuse_bank #(.ID_VALUE(ID_V), .KEY_PRI_INIT(KEY_PI), .KEY_RED_INIT(KEY_RI),
                   .CTRL_PRI_INIT(CTRL_PI), .CTRL_RED_INIT(CTRL_RI)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .shift_i(shift_v[0]), .tdi_i(tdi),
      .capture_i(cap_v[0]), .program_i(prog_v[0]), .tdo_o(tdo_v[0]));

   // Control-lock copy at bit 7 burnt in the primary cell.
   otp_fuse_bank #(.ID_VALUE(ID_V), .KEY_PRI_INIT(KEY_PI), .KEY_RED_INIT(KEY_RI),
                   .CTRL_PRI_INIT(32'h0000_0080), .CTRL_RED_INIT(32'h0)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .shift_i(shift_v[1]), .tdi_i(tdi),
      .capture_i(cap_v[1]), .program_i(prog_v[1]), .tdo_o(tdo_v[1]));

   // Key-lock copy at bit 9 burnt in the redundant cell only.
   otp_fuse_bank #(.ID_VALUE(ID_V), .KEY_PRI_INIT(KEY_PI), .KEY_RED_INIT(KEY_RI),
                   .CTRL_PRI_INIT(32'h0), .CTRL_RED_INIT(32'h0000_0200)) dut_c_i (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .shift_i(shift_v[2]), .tdi_i(tdi),
      .capture_i(cap_v[2]), .program_i(prog_v[2]), .tdo_o(tdo_v[2]));

   // Monitor: compare each shifted bit with the queued expectation.
   always @(posedge clk) begin
      if (rst_n && shift_v[mon_inst]) begin
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard underflow: got %b expected <none>", tdo_v[mon_inst]);
         end else begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if (tdo_v[mon_inst] !== it.val) begin
               errors++;
               $display("FAIL %s inst %0d bit %0d: got %b expected %b",
                        it.tag, mon_inst, it.pos, tdo_v[mon_inst], it.val);
            end
         end
      end
   end

   task automatic check_bit(string tag, logic got, logic expv);
      checks++;
      if (got !== expv) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, got, expv);
      end
   endtask

   task automatic do_capture(int inst, logic [1:0] s);
      @(negedge clk);
      sel = s;
      cap_v[inst] = 1'b1;
      @(negedge clk);
      cap_v[inst] = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_program(int inst, logic [1:0] s);
      @(negedge clk);
      sel = s;
      prog_v[inst] = 1'b1;
      @(negedge clk);
      prog_v[inst] = 1'b0;
   endtask

   // Driver: pushes the expected stream and shifts new data in, both in fuse-index order.
   task automatic do_read(int inst, logic [1:0] s, int w, bit msb_first,
                          logic [255:0] expv, logic [255:0] din, string tag);
      sel = s;
      mon_inst = inst;
      for (int k = 0; k < w; k++) begin
         int   idx;
         exp_t it;
         idx = msb_first ? (w - 1 - k) : k;
         @(negedge clk);
         it.val = expv[idx];
         it.tag = tag;
         it.pos = idx;
         exp_q.push_back(it);
         tdi = din[idx];
         shift_v[inst] = 1'b1;
      end
      @(negedge clk);
      shift_v[inst] = 1'b0;
      tdi = 1'b0;
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL %s: got %0d unchecked bits expected 0", tag, exp_q.size());
         exp_q.delete();
      end
   endtask

   initial begin
      logic [255:0] p1;
      logic [31:0]  ctrl_exp;
      p1 = (256'd1 << 255) | 256'd1 | (256'hA5 << 100);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      sel = 2'b00;
      @(negedge clk);
      // R10: chains empty before any capture
      check_bit("R10 key tdo after reset", tdo_v[0], 1'b0);
      check_bit("R10 key tdo after reset inst b", tdo_v[1], 1'b0);
      check_bit("R10 key tdo after reset inst c", tdo_v[2], 1'b0);

      // R1 R2: key image is OR of cells, index 255 first; p1 enters in the same order
      do_capture(0, 2'b00);
      do_read(0, 2'b00, 256, 1'b1, KEY_OR, p1, "R1 R2 key initial");
      do_program(0, 2'b00);
      do_capture(0, 2'b00);
      // R9: select 11 keeps the output low; key chain[0] now holds bit 255 = 1
      sel = 2'b11;
      #1;
      check_bit("R9 idle select output", tdo_v[0], 1'b0);
      sel = 2'b00;
      #1;
      check_bit("R2 key bit 255 leads", tdo_v[0], 1'b1);
      // R5: bit 3 was 1 and programmed with 0, stays 1
      do_read(0, 2'b00, 256, 1'b1, KEY_OR | p1, '0, "R5 key after program");

      // R4: identifier, index 56 first; a program strobe on it changes nothing
      do_capture(0, 2'b01);
      do_read(0, 2'b01, 57, 1'b1, {199'b0, ID_V}, {256{1'b1}}, "R4 id read");
      do_program(0, 2'b01);
      do_capture(0, 2'b01);
      do_read(0, 2'b01, 57, 1'b1, {199'b0, ID_V}, '0, "R4 id after program strobe");
      do_capture(0, 2'b00);
      do_read(0, 2'b00, 256, 1'b1, KEY_OR | p1, '0, "R4 key untouched by id strobe");

      // R3: control word, index 0 first
      do_capture(0, 2'b10);
      do_read(0, 2'b10, 32, 1'b0, {224'b0, CTRL_PI | CTRL_RI}, {224'b0, 32'h8000_0021}, "R3 ctrl initial");
      do_program(0, 2'b10);
      ctrl_exp = CTRL_PI | CTRL_RI | 32'h8000_0021;
      do_capture(0, 2'b10);
      do_read(0, 2'b10, 32, 1'b0, {224'b0, ctrl_exp}, {224'b0, (32'd1 << 14) | (32'd1 << 20)}, "R3 R5 ctrl after program");
      // R8: lock bit 14 and bit 20 written together
      do_program(0, 2'b10);
      ctrl_exp = ctrl_exp | (32'd1 << 14) | (32'd1 << 20);
      do_capture(0, 2'b10);
      do_read(0, 2'b10, 32, 1'b0, {224'b0, ctrl_exp}, {224'b0, (32'd1 << 12) | (32'd1 << 22)}, "R8 ctrl with new key lock");
      do_program(0, 2'b10);
      // R6: key lock copy at 14 blanks key readback
      do_capture(0, 2'b00);
      do_read(0, 2'b00, 256, 1'b1, '0, '0, "R6 key locked by bit 14");
      // R7: control lock copy at 12 blanks control readback
      do_capture(0, 2'b10);
      do_read(0, 2'b10, 32, 1'b0, '0, '0, "R7 ctrl locked by bit 12");
      do_capture(0, 2'b01);
      do_read(0, 2'b01, 57, 1'b1, {199'b0, ID_V}, '0, "R9 id readable under locks");

      // R7: instance b, control lock copy at 7; program of key lock bit 9 dropped
      do_capture(1, 2'b00);
      do_read(1, 2'b00, 256, 1'b1, KEY_OR, '0, "R7 inst b key open");
      do_capture(1, 2'b10);
      do_read(1, 2'b10, 32, 1'b0, '0, {224'b0, 32'h0000_0200}, "R7 inst b ctrl locked by bit 7");
      do_program(1, 2'b10);
      do_capture(1, 2'b00);
      do_read(1, 2'b00, 256, 1'b1, KEY_OR, '0, "R7 inst b ctrl program dropped");

      // R6: instance c, key lock copy at 9 in the redundant cell only
      do_capture(2, 2'b00);
      do_read(2, 2'b00, 256, 1'b1, '0, '0, "R6 inst c key locked by bit 9");
      do_capture(2, 2'b10);
      do_read(2, 2'b10, 32, 1'b0, {224'b0, 32'h0000_0200}, '0, "R1 inst c ctrl redundant cell sensed");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule